// File: doc/BRIEF.md
# Reflected CRC-16 Accumulator and Frame Checker

This block accumulates the 16-bit cyclic redundancy check that protects frames of the binary serial command protocol. The register is preset to all ones when a frame begins. Each data byte is folded into its low eight bits, and the register then takes eight right-shift steps, each conditioned on the reflected polynomial A001H. Bytes arrive one per `in_valid` strobe. The `in_ready` output tells the sender when the next byte may be presented.

A parameter selects one of two datapaths. The serial datapath resolves one bit per clock, so each byte takes eight cycles. The unrolled datapath chains eight bit steps and absorbs a byte in every cycle. The running value appears on `crc_wire` already swapped into wire order, so its upper byte is the one sent first. When the receiver feeds a frame through the block together with its two trailing check bytes, an intact frame leaves a zero residue, and `frame_ok` reports this.

Top module: `crc16_engine`

## Requirements
- R1: After reset the internal register holds FFFFH, so `crc_wire` reads FFFFH, `in_ready` is 1 and `frame_ok` is 0.
- R2: A `frame_start` pulse reloads FFFFH on the next edge. This takes priority over an `in_valid` in the same cycle, which is then not consumed, and it also aborts a byte that is partly processed (`in_ready` is 1 on the next cycle).
- R3: Each accepted byte is XORed into bits 7:0 of the register and followed by eight steps. Each step shifts right with a zero entering bit 15, then XORs A001H when the bit shifted out was 1. For the bytes 01 03 10 00 00 02 the register ends at CBC0H.
- R4: `crc_wire[15:8]` carries register bits 7:0, the first byte on the line, and `crc_wire[7:0]` carries register bits 15:8. The example frame above therefore gives `crc_wire` = C0CBH.
- R5: With SERIAL=1, a byte accepted at clock edge k drives `in_ready` low through edge k+7, and the next byte can be accepted at edge k+8.
- R6: With SERIAL=1, `in_valid` strobes while `in_ready` is 0 are ignored and do not change the result.
- R7: `frame_ok` is 1 exactly when `in_ready` is 1 and the register is 0000H. Feeding a frame and then its two check bytes, low byte first, sets it, and a corrupted check byte leaves it at 0.
- R8: With SERIAL=0, `in_ready` stays 1 and back-to-back bytes, one per cycle, give the same values as the serial form.
- R9: With no strobe and no start, an idle block holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Reload the preset and begin a new frame |
| in_valid | input | 1 | A data byte is presented |
| in_byte | input | 8 | Data byte |
| in_ready | output | 1 | A byte may be accepted this cycle |
| crc_wire | output | 16 | Current CRC in wire order (first byte in the upper half) |
| frame_ok | output | 1 | Zero residue with the engine idle |

## Verification
The known six-byte read frame pins the exact polynomial, preset, shift direction and output byte swap. A mirrored or non-reflected variant gives a different value there. Random frames from a fixed seed, 1 to 10 bytes long, are checked on both datapaths against a bench bit-loop model, and each frame is then closed with its own check bytes to show the zero residue. The same frames closed with a flipped bit show that `frame_ok` can fall. Directed cases cover the following: strobes held during the busy window, which would corrupt the value if they were consumed; a start coinciding with a strobe and a start arriving mid-byte, which separate the two orders of priority; and idle gaps, which would show any drift.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
  localparam int unsigned CRC_W  = 16;
  localparam int unsigned BYTE_W = 8;
  typedef logic [CRC_W-1:0] crc_t;
  localparam crc_t CRC_PRESET    = 16'hFFFF;
  localparam crc_t CRC_POLY_REFL = 16'hA001;
endpackage

// File: rtl/crc16_bit_step.sv
module crc16_bit_step #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] POLY = 16'hA001
) (
  input  logic [W-1:0] crc_in,
  output logic [W-1:0] crc_out
);
  logic [W-1:0] shifted;

  always_comb begin
    shifted = crc_in >> 1;
    if (crc_in[0]) begin
      crc_out = shifted ^ POLY;
    end else begin
      crc_out = shifted;
    end
  end
endmodule

// File: rtl/crc16_byte_unroll.sv
module crc16_byte_unroll #(
  parameter int unsigned W  = 16,
  parameter int unsigned DW = 8,
  parameter logic [W-1:0] POLY = 16'hA001
) (
  input  logic [W-1:0]  crc_in,
  input  logic [DW-1:0] byte_in,
  output logic [W-1:0]  crc_out
);
  logic [W-1:0] stage [DW+1];

  assign stage[0] = crc_in ^ {{(W-DW){1'b0}}, byte_in};

  for (genvar i = 0; i < DW; i++) begin : g_step
    crc16_bit_step #(.W(W), .POLY(POLY)) u_step (
      .crc_in (stage[i]),
      .crc_out(stage[i+1])
    );
  end

  assign crc_out = stage[DW];
endmodule

// File: rtl/crc16_seq_ctrl.sv
module crc16_seq_ctrl #(
  parameter int unsigned DW = 8,
  localparam int unsigned CNT_W = (DW > 2) ? $clog2(DW) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic accept_i,
  output logic busy_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (start_i) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (accept_i) begin
      cnt_d  = CNT_W'(DW - 1);
      cnt_en = 1'b1;
    end else if (busy_o) begin
      cnt_d  = cnt_q - CNT_W'(1);
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign busy_o = (cnt_q != '0);

  // R5
  accept_goes_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_i && !start_i) |=> busy_o);

  // R6
  busy_counts_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !start_i) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/crc16_engine.sv
module crc16_engine
  import crc16_pkg::*;
#(
  parameter bit           SERIAL = 1'b1,
  parameter int unsigned  DW     = BYTE_W,
  parameter logic [15:0]  POLY   = CRC_POLY_REFL,
  parameter logic [15:0]  PRESET = CRC_PRESET
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_start,
  input  logic        in_valid,
  input  logic [7:0]  in_byte,
  output logic        in_ready,
  output logic [15:0] crc_wire,
  output logic        frame_ok
);
  localparam int unsigned W = CRC_W;

  crc_t crc_q;
  crc_t crc_d;
  logic crc_en;
  logic accept;
  logic busy;
  crc_t upd;

  assign accept = in_valid && in_ready && !frame_start;

  if (SERIAL) begin : g_serial
    crc_t step_in;
    crc16_seq_ctrl #(.DW(DW)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (frame_start),
      .accept_i(accept),
      .busy_o  (busy)
    );
    assign step_in = accept ? (crc_q ^ {{(W-DW){1'b0}}, in_byte[DW-1:0]}) : crc_q;
    crc16_bit_step #(.W(W), .POLY(POLY)) u_step (
      .crc_in (step_in),
      .crc_out(upd)
    );
  end else begin : g_unrolled
    assign busy = 1'b0;
    crc16_byte_unroll #(.W(W), .DW(DW), .POLY(POLY)) u_unroll (
      .crc_in (crc_q),
      .byte_in(in_byte[DW-1:0]),
      .crc_out(upd)
    );
  end

  assign in_ready = !busy;

  always_comb begin
    crc_d  = crc_q;
    crc_en = 1'b0;
    if (frame_start) begin
      crc_d  = PRESET;
      crc_en = 1'b1;
    end else if (accept || busy) begin
      crc_d  = upd;
      crc_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= PRESET;
    end else if (crc_en) begin
      crc_q <= crc_d;
    end
  end

  assign crc_wire = {crc_q[7:0], crc_q[15:8]};
  assign frame_ok = in_ready && (crc_q == '0);

  // R2
  preset_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (crc_wire == {PRESET[7:0], PRESET[15:8]} && in_ready));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid && !frame_start) |=> $stable(crc_wire));

  // R7
  ok_means_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |-> (crc_wire == 16'h0000));
endmodule

// File: tb/sim_crc16_engine.sv
module sim_crc16_engine;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n;
  logic       start;
  logic       valid0, valid1;
  logic [7:0] data;
  logic       ready0, ready1, ok0, ok1;
  logic [15:0] wire0, wire1;
  logic [15:0] exp0, exp1;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  crc16_engine #(.SERIAL(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_start(start), .in_valid(valid0),
    .in_byte(data), .in_ready(ready0), .crc_wire(wire0), .frame_ok(ok0));

  crc16_engine #(.SERIAL(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .frame_start(start), .in_valid(valid1),
    .in_byte(data), .in_ready(ready1), .crc_wire(wire1), .frame_ok(ok1));

  function automatic logic [15:0] ref_byte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {8'h00, b};
    for (int i = 0; i < 8; i++) begin
      if (r[0]) r = (r >> 1) ^ 16'hA001;
      else      r = r >> 1;
    end
    return r;
  endfunction

  function automatic logic [15:0] swap(input logic [15:0] r);
    return {r[7:0], r[15:8]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic new_frame();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    exp0 = 16'hFFFF;
    exp1 = 16'hFFFF;
  endtask

  task automatic send0(input logic [7:0] b, input bit noise, output int lat);
    @(negedge clk);
    data = b; valid0 = 1'b1;
    @(negedge clk);
    exp0 = ref_byte(exp0, b);
    lat = 1;
    if (noise) data = ~b; else valid0 = 1'b0;
    while (!ready0) begin
      @(negedge clk);
      lat++;
    end
    valid0 = 1'b0;
  endtask

  task automatic send1(input logic [7:0] b);
    @(negedge clk);
    data = b; valid1 = 1'b1;
    exp1 = ref_byte(exp1, b);
  endtask

  task automatic end1();
    @(negedge clk);
    valid1 = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] frm [16];
    logic [7:0] known [6];
    logic [15:0] keep;
    int lat;
    int len;
    int unsigned seed;
    known = '{8'h01, 8'h03, 8'h10, 8'h00, 8'h00, 8'h02};
    seed = $urandom(32'd2024);
    rst_n = 1'b0; start = 1'b0; valid0 = 1'b0; valid1 = 1'b0; data = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 crc", wire0, 16'hFFFF);
    chk("R1 ready", ready0, 1'b1);
    chk("R1 ok", ok0, 1'b0);

    // Known frame, serial, with a latency check (R5)
    new_frame();
    for (int i = 0; i < 6; i++) begin
      send0(known[i], 1'b0, lat);
      if (i == 0) chk("R5 latency", lat, 8);
    end
    chk("R3 R4 known serial", wire0, 16'hC0CB);
    chk("R7 ok low before check bytes", ok0, 1'b0);
    repeat (5) @(negedge clk);
    chk("R9 idle hold", wire0, 16'hC0CB);
    send0(8'hC0, 1'b0, lat);
    send0(8'hCB, 1'b0, lat);
    chk("R7 residue ok", ok0, 1'b1);

    // Known frame, unrolled, back to back (R8)
    new_frame();
    for (int i = 0; i < 6; i++) begin
      send1(known[i]);
      if (i > 0) chk("R8 ready stays high", ready1, 1'b1);
    end
    end1();
    chk("R8 known unrolled", wire1, 16'hC0CB);

    // Strobes held through the busy window (R6)
    new_frame();
    send0(8'h5A, 1'b1, lat);
    send0(8'h3C, 1'b1, lat);
    chk("R6 busy strobes ignored", wire0, swap(exp0));

    // Start with a simultaneous strobe (R2)
    send0(8'h77, 1'b0, lat);
    @(negedge clk);
    start = 1'b1; valid0 = 1'b1; valid1 = 1'b1; data = 8'h99;
    @(negedge clk);
    start = 1'b0; valid0 = 1'b0; valid1 = 1'b0;
    chk("R2 start wins serial", wire0, 16'hFFFF);
    chk("R2 start wins unrolled", wire1, 16'hFFFF);
    chk("R2 not busy", ready0, 1'b1);

    // Start in mid-byte (R2)
    @(negedge clk);
    data = 8'hA5; valid0 = 1'b1;
    @(negedge clk);
    valid0 = 1'b0;
    repeat (2) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 abort ready", ready0, 1'b1);
    chk("R2 abort preset", wire0, 16'hFFFF);

    // Random frames on both datapaths
    for (int f = 0; f < 16; f++) begin
      len = 1 + ($urandom % 10);
      for (int i = 0; i < len; i++) frm[i] = 8'($urandom);
      new_frame();
      for (int i = 0; i < len; i++) send0(frm[i], 1'b0, lat);
      chk("R3 random serial", wire0, swap(exp0));
      for (int i = 0; i < len; i++) send1(frm[i]);
      end1();
      chk("R8 random unrolled", wire1, swap(exp1));
      keep = exp0;
      if (f % 2 == 0) begin
        send0(keep[7:0], 1'b0, lat);
        send0(keep[15:8], 1'b0, lat);
        chk("R7 random residue", ok0, 1'b1);
        send1(keep[7:0]); send1(keep[15:8]); end1();
        chk("R7 random residue unrolled", ok1, 1'b1);
      end else begin
        send0(keep[7:0] ^ 8'h01, 1'b0, lat);
        send0(keep[15:8], 1'b0, lat);
        chk("R7 corrupt rejected", ok0, 1'b0);
      end
    end
    finish_run();
  end
endmodule